// File: doc/BRIEF.md
# Transfer Counter and Byte FIFO

This block is the byte data path of a bus controller. A host port moves bytes into and out of a 16-entry FIFO. A bus-side byte stream, either inbound or outbound, shares that FIFO. A 24-bit transfer counter limits how many bytes the bus side may move. The host stages the count one byte at a time into three staging registers. A command write with the DMA bit set copies the staged value into the live counter.

Each byte that crosses the bus side lowers the counter by one. When the counter reaches zero, bus traffic stops until the next load. A completion pulse is raised once the counter is zero and the FIFO has drained toward its destination. The host can flush the FIFO with a command. A flags byte reports FIFO occupancy together with the sequence step of a neighbouring sequencer. By parameter, bit 5 of that byte can carry a synchronous-offset-nonzero indication in place of a step bit.

Host accesses use a 4-bit register index. Index 0 is the count low byte, 1 the middle byte, 14 the high byte, 2 the FIFO, 3 the command, 4 the status and 7 the flags. The `dir_rx` input picks the bus direction: 1 means the bus fills the FIFO, 0 means the FIFO feeds the bus.

Top module: `xfer_path`

## Requirements
- R1: After reset the counter is zero, `tc_zero` is 1, the FIFO is empty, a status read returns 0x10 and `xfer_done` is 0.
- R2: Writes to index 0, 1 and 14 only stage the low, middle and high count bytes. The live counter takes all 24 staged bits only on a command write (index 3) with bit 7 set. Reads of index 0, 1 and 14 return the live counter bytes.
- R3: Each byte accepted on the bus side lowers the counter by exactly one. Status bit 4 and `tc_zero` are 1 exactly when the counter is zero.
- R4: While the counter is zero, `bin_ready` and `bout_valid` are both 0.
- R5: The FIFO holds 16 bytes in first-in first-out order. Host writes and reads use index 2. With `dir_rx`=1 the bus pushes into the FIFO; with `dir_rx`=0 the FIFO head drives `bout_data`.
- R6: A host write to a full FIFO is ignored. A host read of an empty FIFO returns 0 and removes nothing.
- R7: A flags read (index 7) returns the FIFO byte count in bits 4:0 and `seq_step` in bits 7:5. With OFFSET_FLAG=1, bit 5 carries `sync_off_nz` instead.
- R8: A command whose low seven bits equal 0x01 empties the FIFO at the next edge. The bus side is stalled in that cycle.
- R9: While armed by a load, `xfer_done` pulses for one cycle, one edge after the counter is zero and the FIFO is empty. Status bit 3 then stays 1 until the next load.
- R10: In any cycle with a host FIFO access or command write, `bin_ready` and `bout_valid` are 0, so the host takes the FIFO first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1: bus fills FIFO, 0: FIFO feeds bus |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_idx | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of `host_rd` |
| seq_step | input | 3 | Sequence step from the sequencer |
| sync_off_nz | input | 1 | Synchronous offset counter nonzero |
| bin_valid | input | 1 | Inbound bus byte valid |
| bin_data | input | 8 | Inbound bus byte |
| bin_ready | output | 1 | Inbound byte accepted at this edge |
| bout_valid | output | 1 | Outbound bus byte valid |
| bout_data | output | 8 | Outbound bus byte |
| bout_ready | input | 1 | Outbound byte taken at this edge |
| tc_zero | output | 1 | Transfer counter is zero |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
Host read data, `bin_ready`, `bout_valid` and `bout_data` are combinational, so they are due in the same cycle as the request. Counter, FIFO occupancy, flags and status reflect an access after the next rising edge. `xfer_done` comes one edge later still, after the edge that left the counter at zero with an empty FIFO. The bench drives every input on the falling edge and samples one time unit later. A bus byte seen as valid and ready there is the one that moves at the coming rising edge. Registered results are read only after that edge has passed. The completion pulse is counted once per low clock phase, so its single-cycle width shows up as an exact count.

// File: rtl/xfer_path_pkg.sv
package xfer_path_pkg;
    localparam logic [3:0] IDX_CNT_LO  = 4'h0;
    localparam logic [3:0] IDX_CNT_MID = 4'h1;
    localparam logic [3:0] IDX_FIFO    = 4'h2;
    localparam logic [3:0] IDX_CMD     = 4'h3;
    localparam logic [3:0] IDX_STATUS  = 4'h4;
    localparam logic [3:0] IDX_FLAGS   = 4'h7;
    localparam logic [3:0] IDX_CNT_HI  = 4'hE;

    localparam logic [6:0] OP_FLUSH    = 7'h01;
    localparam int         CMD_DMA_BIT = 7;

    localparam int STAT_ZERO_BIT = 4;
    localparam int STAT_DONE_BIT = 3;

    typedef struct packed {
        logic armed;
        logic pulse;
        logic seen;
    } done_state_t;
endpackage

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    input  logic                         flush,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop  && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)) else $error("fifo count beyond depth"); // R6

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty) else $error("flush left data"); // R8

    AST_FULL_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count))) else $error("write to full changed count"); // R6
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [((CNT_W+7)/8)-1:0]    byte_we,
    input  logic [7:0]                  wdata,
    input  logic                        load,
    input  logic                        dec,
    output logic [CNT_W-1:0]            count,
    output logic                        zero
);
    localparam int NB = (CNT_W + 7) / 8;

    typedef struct packed {
        logic [NB-1:0][7:0] stage;
        logic [CNT_W-1:0]   cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NB; b++) begin
            if (byte_we[b]) begin
                st_d.stage[b] = wdata;
            end
        end
        if (load) begin
            st_d.cnt = CNT_W'(st_q.stage);
        end else if (dec && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign zero  = (st_q.cnt == '0);

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (count == $past(count) - CNT_W'(1))) else $error("counter step wrong"); // R3

    AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && zero)) else $error("byte moved at zero count"); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(count)) else $error("counter drifted"); // R2
endmodule

// File: rtl/xfer_flags.sv
module xfer_flags #(
    parameter int  CW          = 5,
    parameter bit  OFFSET_FLAG = 1'b0
) (
    input  logic [CW-1:0] fifo_count,
    input  logic [2:0]    seq_step,
    input  logic          sync_off_nz,
    output logic [7:0]    flags
);
    always_comb begin
        flags = {seq_step, 5'(fifo_count)};
        if (OFFSET_FLAG) begin
            flags[5] = sync_off_nz;
        end
    end
endmodule

// File: rtl/xfer_path.sv
module xfer_path
    import xfer_path_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int CNT_W       = 24,
    parameter bit OFFSET_FLAG = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_rx,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [3:0] host_idx,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [2:0] seq_step,
    input  logic       sync_off_nz,
    input  logic       bin_valid,
    input  logic [7:0] bin_data,
    output logic       bin_ready,
    output logic       bout_valid,
    output logic [7:0] bout_data,
    input  logic       bout_ready,
    output logic       tc_zero,
    output logic       xfer_done
);
    localparam int NB = (CNT_W + 7) / 8;
    localparam int FC = $clog2(DEPTH + 1);

    logic           wr_fifo, rd_fifo, cmd_wr, flush, load, bus_hold;
    logic           rx_move, tx_move, push, pop, dec;
    logic [7:0]     push_data, head, flags;
    logic [FC-1:0]  fifo_count;
    logic           fifo_full, fifo_empty, cnt_zero;
    logic [CNT_W-1:0] cnt;
    logic [NB-1:0]  byte_we;

    done_state_t    dn_d, dn_q;

    // host decode
    always_comb begin
        wr_fifo  = host_wr && (host_idx == IDX_FIFO);
        rd_fifo  = host_rd && (host_idx == IDX_FIFO);
        cmd_wr   = host_wr && (host_idx == IDX_CMD);
        flush    = cmd_wr && (host_wdata[6:0] == OP_FLUSH);
        load     = cmd_wr && host_wdata[CMD_DMA_BIT];
        bus_hold = wr_fifo || rd_fifo || cmd_wr;
        byte_we  = '0;
        byte_we[0]    = host_wr && (host_idx == IDX_CNT_LO);
        byte_we[1]    = host_wr && (host_idx == IDX_CNT_MID);
        byte_we[NB-1] = host_wr && (host_idx == IDX_CNT_HI);
    end

    // bus side
    always_comb begin
        bin_ready  = dir_rx  && !cnt_zero && !fifo_full  && !bus_hold;
        bout_valid = !dir_rx && !cnt_zero && !fifo_empty && !bus_hold;
        bout_data  = head;
        rx_move    = bin_valid && bin_ready;
        tx_move    = bout_valid && bout_ready;
        push       = rx_move || (wr_fifo && !fifo_full);
        push_data  = rx_move ? bin_data : host_wdata;
        pop        = tx_move || (rd_fifo && !fifo_empty);
        dec        = rx_move || tx_move;
    end

    xfer_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .flush     (flush),
        .head      (head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (byte_we),
        .wdata   (host_wdata),
        .load    (load),
        .dec     (dec),
        .count   (cnt),
        .zero    (cnt_zero)
    );

    xfer_flags #(.CW(FC), .OFFSET_FLAG(OFFSET_FLAG)) u_flags (
        .fifo_count  (fifo_count),
        .seq_step    (seq_step),
        .sync_off_nz (sync_off_nz),
        .flags       (flags)
    );

    // completion tracking
    always_comb begin
        dn_d       = dn_q;
        dn_d.pulse = 1'b0;
        if (load) begin
            dn_d.armed = 1'b1;
            dn_d.seen  = 1'b0;
        end else if (dn_q.armed && cnt_zero && fifo_empty) begin
            dn_d.armed = 1'b0;
            dn_d.pulse = 1'b1;
            dn_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_q <= '0;
        end else begin
            dn_q <= dn_d;
        end
    end

    // host read mux
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (host_idx)
                IDX_CNT_LO:  host_rdata = 8'(cnt);
                IDX_CNT_MID: host_rdata = 8'(cnt >> 8);
                IDX_CNT_HI:  host_rdata = 8'(cnt >> (8 * (NB - 1)));
                IDX_FIFO:    host_rdata = fifo_empty ? 8'h00 : head;
                IDX_STATUS: begin
                    host_rdata[STAT_ZERO_BIT] = cnt_zero;
                    host_rdata[STAT_DONE_BIT] = dn_q.seen;
                end
                IDX_FLAGS:   host_rdata = flags;
                default:     host_rdata = '0;
            endcase
        end
    end

    assign tc_zero   = cnt_zero;
    assign xfer_done = dn_q.pulse;

    AST_ZERO_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_zero |-> (!bin_ready && !bout_valid)) else $error("bus open at zero"); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done) else $error("done wider than one cycle"); // R9

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> ($past(tc_zero) && $past(fifo_empty))) else $error("done without drain"); // R9

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fifo && fifo_empty) |-> (host_rdata == 8'h00)) else $error("empty read nonzero"); // R6

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fifo || rd_fifo || cmd_wr) |-> (!bin_ready && !bout_valid)) else $error("bus beat during host access"); // R10
endmodule

// File: tb/xfer_path_tb_top.sv
module xfer_path_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_rx = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_idx = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, rdata_off;
    logic [2:0] seq_step = '0;
    logic       sync_off_nz = 1'b0;
    logic       bin_valid = 1'b0;
    logic [7:0] bin_data = '0;
    logic       bin_ready, bout_valid, bout_ready = 1'b0;
    logic [7:0] bout_data;
    logic       tc_zero, xfer_done;
    logic       o_bin_ready, o_bout_valid, o_tc_zero, o_done;
    logic [7:0] o_bout_data;

    int checks = 0, failures = 0, done_pulses = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    xfer_path dut_i (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .host_wr(host_wr), .host_rd(host_rd),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_step(seq_step), .sync_off_nz(sync_off_nz), .bin_valid(bin_valid),
        .bin_data(bin_data), .bin_ready(bin_ready), .bout_valid(bout_valid),
        .bout_data(bout_data), .bout_ready(bout_ready), .tc_zero(tc_zero), .xfer_done(xfer_done)
    );

    xfer_path #(.OFFSET_FLAG(1'b1)) dut_off_i (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .host_wr(host_wr), .host_rd(host_rd),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(rdata_off),
        .seq_step(seq_step), .sync_off_nz(sync_off_nz), .bin_valid(bin_valid),
        .bin_data(bin_data), .bin_ready(o_bin_ready), .bout_valid(o_bout_valid),
        .bout_data(o_bout_data), .bout_ready(bout_ready), .tc_zero(o_tc_zero), .xfer_done(o_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic hwrite(input logic [3:0] idx, input logic [7:0] d);
        host_wr = 1'b1; host_idx = idx; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] idx, output logic [7:0] d, output logic [7:0] d_off);
        host_rd = 1'b1; host_idx = idx;
        #1;
        d = host_rdata; d_off = rdata_off;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        hwrite(4'h2, d);
        tx_q.push_back(d);
    endtask

    task automatic pop_host(input string req);
        logic [7:0] d, d2;
        hread(4'h2, d, d2);
        if (rx_q.size() == 0) check({req, " unexpected read"}, 1, 0);
        else check(req, d, rx_q.pop_front());
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: outbound beats and completion pulses
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (xfer_done) done_pulses++;
            if (bout_valid && bout_ready) begin
                if (tx_q.size() == 0) check("R5 unexpected outbound byte", {24'h0, bout_data}, 32'hFFFF);
                else check("R5 outbound order", bout_data, tx_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d, d2;
        int acc;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 tc_zero", tc_zero, 1);
        check("R1 xfer_done", xfer_done, 0);
        hread(4'h4, d, d2); check("R1 status", d, 8'h10);
        hread(4'h7, d, d2); check("R1 flags", d, 8'h00);

        // R2 staging does not touch the live count
        hwrite(4'h0, 8'h03);
        hread(4'h0, d, d2); check("R2 staged not live", d, 8'h00);

        // outbound: 5 bytes queued, count 3
        dir_rx = 1'b0;
        for (int i = 0; i < 5; i++) push_tx(8'h11 + 8'(i));
        hread(4'h7, d, d2); check("R7 flags count 5", d, 8'h05);
        hwrite(4'h3, 8'h80);
        hread(4'h0, d, d2); check("R2 loaded low byte", d, 8'h03);
        check("R3 tc_zero after load", tc_zero, 0);
        bout_ready = 1'b1;
        idle(10);
        check("R3 counter reached zero", tc_zero, 1);
        check("R4 bout_valid low at zero", bout_valid, 0);
        hread(4'h7, d, d2); check("R4 two bytes left", d, 8'h02);
        check("R9 no done with bytes left", done_pulses, 0);
        check("R5 queue left", tx_q.size(), 2);
        hwrite(4'h3, 8'h01);
        tx_q.delete();
        idle(3);
        hread(4'h7, d, d2); check("R8 flushed", d, 8'h00);
        check("R9 one done pulse", done_pulses, 1);
        hread(4'h4, d, d2); check("R9 status sticky done", d, 8'h18);

        // R5/R6 full and empty handling, bus stalled by zero count
        for (int i = 0; i < 17; i++) hwrite(4'h2, 8'h40 + 8'(i));
        hread(4'h7, d, d2); check("R6 full count", d, 8'h10);
        for (int i = 0; i < 16; i++) begin
            hread(4'h2, d, d2); check("R5 fifo order", d, 8'h40 + 8'(i));
        end
        hread(4'h2, d, d2); check("R6 empty read zero", d, 8'h00);
        hread(4'h7, d, d2); check("R6 still empty", d, 8'h00);

        // R2 full 24-bit load and readback
        hwrite(4'h0, 8'h34); hwrite(4'h1, 8'h12); hwrite(4'hE, 8'h56);
        hwrite(4'h3, 8'h80);
        hread(4'h0, d, d2); check("R2 low", d, 8'h34);
        hread(4'h1, d, d2); check("R2 mid", d, 8'h12);
        hread(4'hE, d, d2); check("R2 high", d, 8'h56);
        hread(4'h4, d, d2); check("R9 load clears done", d, 8'h00);

        // inbound: count 4
        dir_rx = 1'b1;
        hwrite(4'h0, 8'h04); hwrite(4'h1, 8'h00); hwrite(4'hE, 8'h00);
        hwrite(4'h3, 8'h80);
        bin_valid = 1'b1; bin_data = 8'hEE;
        host_wr = 1'b1; host_idx = 4'h2; host_wdata = 8'h5A;
        #1;
        check("R10 host write stalls bus", bin_ready, 0);
        rx_q.push_back(8'h5A);
        @(negedge clk);
        host_wr = 1'b0;
        acc = 0;
        for (int i = 0; i < 6; i++) begin
            bin_data = 8'hA0 + 8'(i);
            #1;
            if (bin_ready) begin
                rx_q.push_back(bin_data);
                acc++;
            end
            @(negedge clk);
        end
        check("R4 bin_ready low at zero", bin_ready, 0);
        bin_valid = 1'b0;
        check("R3 four bytes accepted", acc, 4);
        hread(4'h0, d, d2); check("R3 counter low zero", d, 8'h00);
        hread(4'h7, d, d2); check("R5 inbound count", d, 8'h05);
        check("R9 no done before drain", done_pulses, 1);
        for (int i = 0; i < 5; i++) pop_host("R5 inbound order");
        idle(2);
        check("R9 done after drain", done_pulses, 2);

        // R7 flags packing, both variants
        seq_step = 3'd5; sync_off_nz = 1'b1;
        hread(4'h7, d, d2);
        check("R7 step field", d, 8'hA0);
        check("R7 offset variant set", d2, 8'hA0);
        sync_off_nz = 1'b0;
        hread(4'h7, d, d2);
        check("R7 step kept", d, 8'hA0);
        check("R7 offset variant clear", d2, 8'h80);
        dir_rx = 1'b0;
        for (int i = 0; i < 3; i++) hwrite(4'h2, 8'h70);
        seq_step = 3'd2;
        hread(4'h7, d, d2);
        check("R7 count with step", d, 8'h43);
        check("R7 offset variant count", d2, 8'h43);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule